// File: doc/BRIEF.md
# Automatic remote alarm controller

This block decides the value of the remote alarm (A) bit that the transmit framer places in each outgoing E1 frame. It watches the receiver's synchronization state: a loss-of-frame-alignment flag and a multiframe-synchronous flag. From these it signals the far end whether the local receiver is locked. When automatic control is off, a software-supplied alarm value passes through unchanged.

In the extended-interworking mode, a 400 ms timer guards the multiframe search. The timer starts once basic frame alignment is held without multiframe lock, and it counts 1 ms ticks. If the timer expires, the alarm goes active and stays active until multiframe sync is found. The alarm output is a register that loads only on a frame-start strobe, so the bit never changes inside a frame. The expiry of the timer is also reported as a status output.

Top module: `ra_auto_ctrl`

## Requirements
- R1: With `auto_en` low, each frame-start strobe loads `sw_alarm` into `alarm_out`, whatever the synchronization inputs are.
- R2: With `auto_en` high and `lfa` high at a frame-start strobe, `alarm_out` becomes 1, even when `mf_sync` is also high.
- R3: With `auto_en` high, `lfa` low, `mf_sync` low and the timeout not taken into account (`ext_mode` low, or `timeout_flag` low), a frame-start strobe makes `alarm_out` 0.
- R4: With `auto_en` and `ext_mode` high, `lfa` and `mf_sync` low and `timeout_flag` high, a frame-start strobe makes `alarm_out` 1.
- R5: With `auto_en` high, `lfa` low and `mf_sync` high, a frame-start strobe makes `alarm_out` 0.
- R6: While `lfa` and `mf_sync` are both low, the timer counts `tick_1ms` pulses. `timeout_flag` rises in the cycle after the 400th tick (TIMEOUT_MS) and stays high while the condition holds.
- R7: Whenever `lfa` or `mf_sync` is high, the timer clears. `timeout_flag` is low in the next cycle, and a later run needs a full 400 new ticks.
- R8: `alarm_out` changes only on the clock edge where `frame_start` is high. It holds its value on every other edge.
- R9: A synchronous reset (`rst` high) makes `alarm_out` 0, makes `timeout_flag` 0 and clears the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_en | input | 1 | 1 = automatic alarm control, 0 = software value |
| ext_mode | input | 1 | 1 = the multiframe-search timeout sets the alarm |
| lfa | input | 1 | Receiver has lost frame alignment |
| mf_sync | input | 1 | Receiver is multiframe synchronous |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| frame_start | input | 1 | One-cycle strobe at the start of each outgoing frame |
| sw_alarm | input | 1 | Software alarm value used when `auto_en` is 0 |
| alarm_out | output | 1 | Remote alarm bit for the transmit framer |
| timeout_flag | output | 1 | The 400 ms multiframe-search timer has expired |

## Verification
A table drives the combinations of the enable, mode, alignment-loss, multiframe-sync and software-alarm inputs with the timer idle. It covers three things:
- the software value passing through, including while alignment is lost;
- alignment loss winning over multiframe sync;
- the extended mode having no effect before expiry.

Directed sequences then check the timer boundary by comparing the flag after 399 and after 400 ticks. They also check that an alignment loss in the middle of a count restarts the full count, and that only multiframe sync lowers the alarm after a timeout in extended mode. Further sequences check that the alarm holds when inputs change between frame strobes, and that reset works in the middle of a run.

// File: rtl/ra_pkg.sv
package ra_pkg;
    localparam int unsigned TIMEOUT_MS_DEF = 400;

    typedef struct packed {
        logic alarm;
    } ra_dec_state_t;
endpackage

// File: rtl/ra_timeout_timer.sv
module ra_timeout_timer #(
    parameter int unsigned TIMEOUT_MS = ra_pkg::TIMEOUT_MS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic lfa,
    input  logic mf_sync,
    input  logic tick_1ms,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_MS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_MS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lfa || mf_sync) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (tick_1ms && !st_q.flag) begin
            if (st_q.cnt == LAST) begin
                st_d.flag = 1'b1;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.flag;
endmodule

// File: rtl/ra_alarm_decide.sv
module ra_alarm_decide (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic ext_mode,
    input  logic lfa,
    input  logic mf_sync,
    input  logic expired,
    input  logic frame_start,
    input  logic sw_alarm,
    output logic alarm
);
    import ra_pkg::*;

    ra_dec_state_t st_d, st_q;
    logic          want;

    always_comb begin
        if (!auto_en) begin
            want = sw_alarm;
        end else if (lfa) begin
            want = 1'b1;
        end else if (mf_sync) begin
            want = 1'b0;
        end else begin
            want = ext_mode && expired;
        end

        st_d = st_q;
        if (frame_start) begin
            st_d.alarm = want;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm = st_q.alarm;
endmodule

// File: rtl/ra_auto_ctrl.sv
module ra_auto_ctrl #(
    parameter int unsigned TIMEOUT_MS = ra_pkg::TIMEOUT_MS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic ext_mode,
    input  logic lfa,
    input  logic mf_sync,
    input  logic tick_1ms,
    input  logic frame_start,
    input  logic sw_alarm,
    output logic alarm_out,
    output logic timeout_flag
);
    logic expired;

    ra_timeout_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .lfa      (lfa),
        .mf_sync  (mf_sync),
        .tick_1ms (tick_1ms),
        .expired  (expired)
    );

    ra_alarm_decide u_decide (
        .clk         (clk),
        .rst         (rst),
        .auto_en     (auto_en),
        .ext_mode    (ext_mode),
        .lfa         (lfa),
        .mf_sync     (mf_sync),
        .expired     (expired),
        .frame_start (frame_start),
        .sw_alarm    (sw_alarm),
        .alarm       (alarm_out)
    );

    assign timeout_flag = expired;
endmodule

// File: rtl/ra_auto_ctrl_chk.sv
module ra_auto_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic auto_en,
    input logic ext_mode,
    input logic lfa,
    input logic mf_sync,
    input logic tick_1ms,
    input logic frame_start,
    input logic sw_alarm,
    input logic alarm_out,
    input logic timeout_flag
);
    p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && frame_start) |=> (alarm_out == $past(sw_alarm)));

    p_lfa_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (auto_en && lfa && frame_start) |=> alarm_out);

    p_insync_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !lfa && !mf_sync && !ext_mode && frame_start) |=> !alarm_out);

    p_timeout_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (auto_en && ext_mode && !lfa && !mf_sync && timeout_flag && frame_start) |=> alarm_out);

    p_mf_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !lfa && mf_sync && frame_start) |=> !alarm_out);

    p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> $past(tick_1ms));

    p_timer_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (lfa || mf_sync) |=> !timeout_flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(alarm_out));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!alarm_out && !timeout_flag));
endmodule

bind ra_auto_ctrl ra_auto_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .auto_en      (auto_en),
    .ext_mode     (ext_mode),
    .lfa          (lfa),
    .mf_sync      (mf_sync),
    .tick_1ms     (tick_1ms),
    .frame_start  (frame_start),
    .sw_alarm     (sw_alarm),
    .alarm_out    (alarm_out),
    .timeout_flag (timeout_flag)
);

// File: tb/test_ra_auto_ctrl.sv
module test_ra_auto_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auto_en = 0, ext_mode = 0, lfa = 0, mf_sync = 0;
    logic tick_1ms = 0, frame_start = 0, sw_alarm = 0;
    logic alarm_out, timeout_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ra_auto_ctrl i_ra_auto_ctrl (
        .clk(clk), .rst(rst), .auto_en(auto_en), .ext_mode(ext_mode),
        .lfa(lfa), .mf_sync(mf_sync), .tick_1ms(tick_1ms),
        .frame_start(frame_start), .sw_alarm(sw_alarm),
        .alarm_out(alarm_out), .timeout_flag(timeout_flag)
    );

    // Bits: [5] auto_en, [4] ext_mode, [3] lfa, [2] mf_sync, [1] sw_alarm, [0] expected alarm
    localparam logic [5:0] VEC [8] = '{
        6'b0_0_0_0_1_1,  // R1 software 1
        6'b0_0_0_0_0_0,  // R1 software 0
        6'b0_0_1_0_0_0,  // R1 lfa ignored
        6'b1_0_1_0_0_1,  // R2 lfa sets
        6'b1_0_0_0_1_0,  // R3 in sync, no mf
        6'b1_0_0_1_0_0,  // R5 mf sync clears
        6'b1_1_0_0_0_0,  // R3 ext mode, no timeout yet
        6'b1_0_1_1_0_1   // R2 lfa beats mf_sync
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic strobe_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 alarm reset", alarm_out, 1'b0);
        check("R9 timeout reset", timeout_flag, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            {auto_en, ext_mode, lfa, mf_sync, sw_alarm} = VEC[i][5:1];
            strobe_frame();
            check($sformatf("R1/R2/R3/R5 vector %0d", i), alarm_out, VEC[i][0]);
        end

        // R8: alarm is 1 now, so change inputs to give 0 but no strobe
        auto_en = 1; ext_mode = 0; lfa = 0; mf_sync = 1; sw_alarm = 0;
        repeat (3) @(negedge clk);
        check("R8 hold without strobe", alarm_out, 1'b1);
        strobe_frame();
        check("R8/R5 update at strobe", alarm_out, 1'b0);

        // R6: timeout boundary
        mf_sync = 0; ext_mode = 1;
        @(negedge clk);
        ticks(399);
        check("R6 no flag after 399 ticks", timeout_flag, 1'b0);
        strobe_frame();
        check("R3 no alarm before timeout", alarm_out, 1'b0);
        ticks(1);
        check("R6 flag after 400 ticks", timeout_flag, 1'b1);
        ticks(5);
        check("R6 flag holds", timeout_flag, 1'b1);
        strobe_frame();
        check("R4 timeout sets alarm", alarm_out, 1'b1);
        ext_mode = 0;
        strobe_frame();
        check("R3 ext off ignores timeout", alarm_out, 1'b0);
        ext_mode = 1;
        strobe_frame();
        check("R4 alarm held until mf sync", alarm_out, 1'b1);
        mf_sync = 1;
        @(negedge clk);
        check("R7 mf sync clears flag", timeout_flag, 1'b0);
        strobe_frame();
        check("R5 mf sync clears alarm", alarm_out, 1'b0);

        // R7: lfa in mid count restarts timer
        mf_sync = 0;
        @(negedge clk);
        ticks(200);
        lfa = 1;
        @(negedge clk);
        lfa = 0;
        @(negedge clk);
        ticks(399);
        check("R7 restart needs full count", timeout_flag, 1'b0);
        ticks(1);
        check("R7 flag after full recount", timeout_flag, 1'b1);
        lfa = 1;
        @(negedge clk);
        check("R7 lfa clears flag", timeout_flag, 1'b0);
        strobe_frame();
        check("R2 lfa sets alarm", alarm_out, 1'b1);

        // R9: reset mid run
        lfa = 0;
        ticks(400);
        rst = 1;
        @(negedge clk);
        check("R9 alarm cleared by reset", alarm_out, 1'b0);
        check("R9 flag cleared by reset", timeout_flag, 1'b0);
        rst = 0;
        @(negedge clk);
        ticks(399);
        check("R9 timer cleared by reset", timeout_flag, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule